// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers interrupt events from a parameterized set of sources and decides when to raise a request to the CPU and which vector it should use. Each source has three control bits: a pending flag, an enable, and a priority select. A small register port gives software read and write access to them and to a control word. Source 0 is an external-pin source. Sources below `CORE_N` are core sources. All sources at or above `CORE_N` are peripheral sources.

The block has two modes. In legacy mode there is one global enable. A second enable additionally gates the peripheral sources, and every interrupt uses the high vector. In priority mode the same two bits become separate enables for high-level and low-level requests. The two levels use different vectors, and a high-level request may interrupt a low-level handler. The block itself accepts each request: it clears the enable that governed the request, records which level is in service, and sets that enable again when the return pulse arrives. A wake output reports any enabled pending source, whatever the state of the global enables.

Top module: `irq_prio_ctrl`

## Requirements
- R1: An event on a source sets that source's flag two clock edges after it is sampled. This happens whatever the state of its enable and of the global enables. A flag stays set until a register write to address 0 replaces the flag vector, and an event in the same cycle as the write wins.
- R2: After reset the flags, enables, priorities and control word all read 0, `irqReq` is 0 and `wake` is 0.
- R3: In priority mode (control bit 2 = 1), a source with flag, enable and priority bit set, while the high enable (control bit 0) is 1, produces a one-cycle `irqReq`. The vector is 0x000008 and control bit 0 is cleared.
- R4: In priority mode, a source with flag and enable set and priority bit clear, while the low enable (control bit 1) is 1, produces `irqReq` with vector 0x000018 and clears control bit 1.
- R5: In legacy mode (control bit 2 = 0), priority bits have no effect. Every request uses vector 0x000008 and clears control bit 0, which acts as the global enable.
- R6: In legacy mode, control bit 1 must also be 1 for peripheral sources (index >= CORE_N) to request. Core sources need only control bit 0.
- R7: Source 0 is always high priority in priority mode, whatever its priority bit.
- R8: A high-level request is taken while a low-level handler is in service. A low-level request is never taken while a high-level handler is in service, even when control bit 1 is 1.
- R9: `retPulse` sets the enable of the level being exited. In priority mode this is control bit 0 if a high-level handler is active, otherwise control bit 1. In legacy mode it is control bit 0.
- R10: `irqReq` asserts after the third rising edge following the edge that samples an event, which lies within the allowed window of three to four cycles.
- R11: `wake` is 1 whenever some source has both flag and enable set, independent of the global enables and the mode.
- R12: The register port uses address 0 for flags, 1 for enables, 2 for priorities and 3 for the control word. Writes take effect on the clock edge, and reads are combinational on `rdAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evt | input | N | Event inputs, one per source, synchronized inside |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | N | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | N | Register read data |
| retPulse | input | 1 | Return-from-interrupt pulse |
| irqReq | output | 1 | One-cycle interrupt request to the CPU |
| vector | output | 24 | Vector address of the most recent request |
| wake | output | 1 | Any enabled source pending |

## Verification
The main sweep covers every source under both modes, both priority-bit values and all four combinations of the two global enables. This separates core from peripheral gating, shows that priority bits are ignored in legacy mode, and shows that source 0 always acts as high priority. For each case the bench checks whether a request appears, its latency, its vector, which enable was cleared, and whether the return pulse restores that enable. A disabled-source pattern shows that flags and wake follow events independently of the enables. A directed sequence (low level taken, then preempted by high, then a low event during the high handler) separates correct preemption from a missing in-service block.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_ADDR_W = 2;
  localparam int VEC_W      = 24;

  localparam logic [REG_ADDR_W-1:0] ADDR_FLAG = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_EN   = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_PRI  = 2'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL = 2'd3;

  localparam logic [VEC_W-1:0] VEC_HI = 24'h000008;
  localparam logic [VEC_W-1:0] VEC_LO = 24'h000018;

  typedef struct packed {
    logic takeHi;
    logic takeLo;
    logic takeLeg;
    logic retHi;
    logic retLo;
    logic retLeg;
  } irq_strobe_t;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [N-1:0]          evt,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] wrAddr,
  input  logic [N-1:0]          wrData,
  input  logic [REG_ADDR_W-1:0] rdAddr,
  input  irq_strobe_t           strobe,
  output logic [N-1:0]          flags,
  output logic [N-1:0]          enables,
  output logic [N-1:0]          prios,
  output logic                  prioMode,
  output logic                  gieHi,
  output logic                  gieLo,
  output logic [N-1:0]          rdData
);
  localparam int PAD_W = N - 3;

  logic [N-1:0] syncA, syncB;
  logic wrFlag, wrEnReg, wrPri, wrCtrl;
  logic gieHiNext, gieLoNext;

  assign wrFlag  = wrEn && (wrAddr == ADDR_FLAG);
  assign wrEnReg = wrEn && (wrAddr == ADDR_EN);
  assign wrPri   = wrEn && (wrAddr == ADDR_PRI);
  assign wrCtrl  = wrEn && (wrAddr == ADDR_CTRL);

  always_comb begin
    gieHiNext = wrCtrl ? wrData[0] : gieHi;
    if (strobe.retHi || strobe.retLeg)   gieHiNext = 1'b1;
    if (strobe.takeHi || strobe.takeLeg) gieHiNext = 1'b0;
    gieLoNext = wrCtrl ? wrData[1] : gieLo;
    if (strobe.retLo)  gieLoNext = 1'b1;
    if (strobe.takeLo) gieLoNext = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      flags    <= '0;
      enables  <= '0;
      prios    <= '0;
      prioMode <= 1'b0;
      gieHi    <= 1'b0;
      gieLo    <= 1'b0;
    end else begin
      syncA    <= evt;
      syncB    <= syncA;
      flags    <= (wrFlag ? wrData : flags) | syncB;
      if (wrEnReg) enables <= wrData;
      if (wrPri)   prios   <= wrData;
      if (wrCtrl)  prioMode <= wrData[2];
      gieHi    <= gieHiNext;
      gieLo    <= gieLoNext;
    end
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_FLAG: rdData = flags;
      ADDR_EN:   rdData = enables;
      ADDR_PRI:  rdData = prios;
      default:   rdData = {{PAD_W{1'b0}}, prioMode, gieLo, gieHi};
    endcase
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int N      = 8,
  parameter int CORE_N = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     flags,
  input  logic [N-1:0]     enables,
  input  logic [N-1:0]     prios,
  input  logic             prioMode,
  input  logic             gieHi,
  input  logic             gieLo,
  input  logic             retPulse,
  output irq_strobe_t      strobe,
  output logic             irqReq,
  output logic [VEC_W-1:0] vector,
  output logic             wake,
  output logic             hiActive,
  output logic             loActive
);
  localparam logic [N-1:0] CORE_MASK = {N{1'b1}} >> (N - CORE_N);
  localparam logic [N-1:0] PIN0_MASK = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] active, hiEff;
  logic hiPend, loPend, legPend;

  assign active  = flags & enables;
  assign hiEff   = prios | PIN0_MASK;
  assign hiPend  = prioMode && gieHi && (|(active & hiEff));
  assign loPend  = prioMode && gieLo && !hiActive && (|(active & ~hiEff));
  assign legPend = !prioMode && gieHi && (|(active & (CORE_MASK | {N{gieLo}})));
  assign wake    = |active;

  always_comb begin
    strobe.takeHi  = hiPend && !retPulse;
    strobe.takeLo  = loPend && !hiPend && !retPulse;
    strobe.takeLeg = legPend && !retPulse;
    strobe.retHi   = retPulse && prioMode && hiActive;
    strobe.retLo   = retPulse && prioMode && !hiActive && loActive;
    strobe.retLeg  = retPulse && !prioMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqReq   <= 1'b0;
      vector   <= '0;
      hiActive <= 1'b0;
      loActive <= 1'b0;
    end else begin
      irqReq <= strobe.takeHi || strobe.takeLo || strobe.takeLeg;
      if (strobe.takeLo)                        vector <= VEC_LO;
      else if (strobe.takeHi || strobe.takeLeg) vector <= VEC_HI;
      if (strobe.retHi || strobe.retLeg) hiActive <= 1'b0;
      if (strobe.takeHi || strobe.takeLeg) hiActive <= 1'b1;
      if (strobe.retLo || strobe.retLeg) loActive <= 1'b0;
      if (strobe.takeLo) loActive <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int N      = 8,
  parameter int CORE_N = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [N-1:0]          evt,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] wrAddr,
  input  logic [N-1:0]          wrData,
  input  logic [REG_ADDR_W-1:0] rdAddr,
  output logic [N-1:0]          rdData,
  input  logic                  retPulse,
  output logic                  irqReq,
  output logic [VEC_W-1:0]      vector,
  output logic                  wake
);
  irq_strobe_t strobe;
  logic [N-1:0] flags, enables, prios;
  logic prioMode, gieHi, gieLo, hiActive, loActive;

  irq_regs #(.N(N)) u_regs (
    .clk(clk), .rstN(rstN), .evt(evt), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .strobe(strobe), .flags(flags),
    .enables(enables), .prios(prios), .prioMode(prioMode), .gieHi(gieHi),
    .gieLo(gieLo), .rdData(rdData)
  );

  irq_ctrl #(.N(N), .CORE_N(CORE_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .flags(flags), .enables(enables), .prios(prios),
    .prioMode(prioMode), .gieHi(gieHi), .gieLo(gieLo), .retPulse(retPulse),
    .strobe(strobe), .irqReq(irqReq), .vector(vector), .wake(wake),
    .hiActive(hiActive), .loActive(loActive)
  );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             irqReq,
  input logic [VEC_W-1:0] vector,
  input logic             wake,
  input logic             retPulse,
  input logic             prioMode,
  input logic             gieHi,
  input logic             gieLo,
  input logic             hiActive
);
  AST_LEGACY_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !$past(prioMode)) |-> (vector == VEC_HI && !gieHi)); // R5
  AST_HI_CLEARS_HI: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && $past(prioMode) && vector == VEC_HI) |-> !gieHi); // R3
  AST_LO_CLEARS_LO: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && $past(prioMode) && vector == VEC_LO) |-> !gieLo); // R4
  AST_NO_LO_UNDER_HI: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && $past(hiActive)) |-> (vector == VEC_HI)); // R8
  AST_RET_LEGACY: assert property (@(posedge clk) disable iff (!rstN)
    (retPulse && !prioMode) |=> gieHi); // R9
  AST_RET_HI_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (retPulse && prioMode && hiActive) |=> gieHi); // R9
  AST_REQ_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> $past(wake)); // R11
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .vector(vector), .wake(wake),
  .retPulse(retPulse), .prioMode(prioMode), .gieHi(gieHi), .gieLo(gieLo),
  .hiActive(hiActive)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  localparam int N = 8;
  localparam int CORE_N = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] evt = '0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [N-1:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [N-1:0] rdData;
  logic retPulse = 1'b0;
  logic irqReq;
  logic [23:0] vector;
  logic wake;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl #(.N(N), .CORE_N(CORE_N)) u_irq_prio_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .retPulse(retPulse),
    .irqReq(irqReq), .vector(vector), .wake(wake)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    rdAddr = a;
    #1 d = rdData;
  endtask

  task automatic pulseRet();
    @(negedge clk);
    retPulse = 1'b1;
    @(negedge clk);
    retPulse = 1'b0;
  endtask

  // Pulse an event, return the edge index (1..6) of the first request, 0 if none.
  task automatic fire(input int s, output int first, output logic [23:0] vec);
    first = 0; vec = '0;
    @(negedge clk);
    evt = N'(1) << s;
    @(negedge clk);
    evt = '0;
    for (int i = 1; i <= 6; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (irqReq && first == 0) begin
        first = i; vec = vector;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] d;
    int first;
    logic [23:0] vec;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check(d == '0, "R2 reset register", int'(d), 0);
    end
    check(!irqReq && !wake, "R2 reset outputs", {irqReq, wake}, 0);

    // R1 / R11: disabled source still flags, no wake, no request
    wr(2'd3, 8'h03);
    fire(2, first, vec);
    rd(2'd0, d);
    check(d == 8'h04, "R1 flag set while disabled", int'(d), 4);
    check(!wake, "R11 wake needs enable", wake, 0);
    check(first == 0, "R1 no request while disabled", first, 0);
    wr(2'd0, 8'h00);
    rd(2'd0, d);
    check(d == 8'h00, "R12 flag write clears", int'(d), 0);

    // Sweep: mode x priority x global enables x source
    for (int mode = 0; mode < 2; mode++)
      for (int pri = 0; pri < 2; pri++)
        for (int g = 0; g < 4; g++)
          for (int s = 0; s < N; s++) begin
            bit gH, gL, hiEff, take;
            logic [23:0] expVec;
            logic [N-1:0] ctrl0, ctrlAfter;
            gH = g[0]; gL = g[1];
            hiEff = (s == 0) || (pri == 1);
            if (mode == 1) begin
              take = hiEff ? gH : gL;
              expVec = hiEff ? 24'h8 : 24'h18;
            end else begin
              take = gH && (s < CORE_N || gL);
              expVec = 24'h8;
            end
            ctrl0 = {5'b0, mode[0], gL, gH};
            ctrlAfter = ctrl0;
            if (take) begin
              if (mode == 1 && !hiEff) ctrlAfter[1] = 1'b0;
              else ctrlAfter[0] = 1'b0;
            end
            wr(2'd3, 8'h00);
            wr(2'd0, 8'h00);
            wr(2'd1, N'(1) << s);
            wr(2'd2, pri ? 8'hFF : 8'h00);
            wr(2'd3, ctrl0);
            fire(s, first, vec);
            if (take) begin
              check(first == 3 || first == 4, "R10 request latency", first, 3);
              check(vec == expVec, mode ? (hiEff ? "R3 R7 high vector" : "R4 low vector")
                                        : "R5 legacy vector", int'(vec), int'(expVec));
            end else begin
              check(first == 0, mode ? "R3 R4 gated by level enable" : "R6 legacy gating",
                    first, 0);
            end
            check(wake, "R11 wake with enabled flag", wake, 1);
            rd(2'd0, d);
            check(d == (N'(1) << s), "R1 flag after event", int'(d), 1 << s);
            rd(2'd3, d);
            check(d == ctrlAfter, "R3 R4 R5 enable cleared on take", int'(d), int'(ctrlAfter));
            if (take) begin
              wr(2'd0, 8'h00);
              pulseRet();
              rd(2'd3, d);
              check(d == ctrl0, "R9 return restores enable", int'(d), int'(ctrl0));
            end
          end

    // R8 preemption sequence: source 5 low, source 6 high
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h60);
    wr(2'd2, 8'h40);
    wr(2'd3, 8'h07);
    fire(5, first, vec);
    check(first == 3 && vec == 24'h18, "R8 low level taken", int'(vec), 24'h18);
    fire(6, first, vec);
    check(first == 3 && vec == 24'h8, "R8 high preempts low", int'(vec), 24'h8);
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h06);
    fire(5, first, vec);
    check(first == 0, "R8 low blocked under high", first, 0);
    pulseRet();
    rd(2'd3, d);
    check(d[0] == 1'b1, "R9 return from high sets high enable", int'(d), 7);
    first = 0;
    for (int i = 1; i <= 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (irqReq && first == 0) begin first = i; vec = vector; end
    end
    check(first != 0 && vec == 24'h18, "R8 low resumes after high exits", int'(vec), 24'h18);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule